// File: doc/BRIEF.md
# DMA Channel Control Register Unit

This block holds the software-visible control state of a set of descriptor-driven DMA channels. A 32-bit bus reaches each channel through an 8 KiB window. The channel number comes from the upper address bits and the register from the low byte. Each channel keeps pointer registers, a configuration word, a command word, an interrupt mask and pending interrupt bits. It also keeps a one-hot run state and an end-of-list flag, and it drives one interrupt line.

The block does not touch descriptor memory. It issues single-cycle requests to a separate data mover: load a data descriptor, load a context descriptor, start, reload the current descriptor, and advance to the next one. It takes back the mover's reports: interrupt events, the end-of-list halt, and the result of a reload. A continue command asks the mover to reload the current descriptor. The channel resumes only if the reloaded copy no longer carries its end-of-list mark.

Top module: `dma_chan_regs`

## Requirements
- R1: The channel is `addr[15:13]` and the register word is `addr[7:2]`. The byte offsets are: data pointer 0x00, saved data 0x58, saved buffer 0x5C, group 0x60, group down 0x7C, command 0x80, config 0x84, status 0x88, mask 0x8C, acknowledge 0x90, pending 0x94, masked 0x98, stream command 0x9C. Pointer, command, config and mask registers read back what was written. A channel number at or above `NCH`, or an unused offset, reads zero.
- R2: After reset every register is zero, the state is RST, and the status word reads 0x101.
- R3: The state is one-hot: RST=1, STOPPED=2, RUNNING=4. A config write with bit0 clear sets RST, even when bit1 is also set. A config write with bit0 set and bit1 set sets STOPPED. A config write with bit0 set and bit1 clear leaves the state as it was.
- R4: The status word has the state in bits [2:0], the end-of-list flag in bit 5, and the constant stream source 1 in bits [9:8].
- R5: A mover event sets pending interrupt bits. A write to the acknowledge register clears the pending bits that are set in the written value, and the acknowledge register always reads zero. If an event and an acknowledge of the same bit fall in one cycle, the event wins.
- R6: The masked register reads pending AND mask. `irq` is high while any masked bit is set.
- R7: A stream command uses bits [9:0] only. If any of bits 0x140 is set, the block pulses `load_data`, and if bit 0x20 is also set it pulses `start`. If bit 0x200 is set, it pulses `load_ctx`. Either pulse comes one cycle after the write.
- R8: A start sets the state to RUNNING and clears the end-of-list flag. `halt_eol` sets that flag.
- R9: A command write pulses `reload_req` only if config bit0 is 1, config bit1 is 0, the state is RUNNING, and `desc_eol` is high.
- R10: When `reload_done` answers such a request with `reload_eol` low, while the end-of-list flag is set and the config still enables the channel, the block pulses `advance` and `start` and restarts the channel. Otherwise nothing changes.
- R11: An access with `size` other than 2 (word) does not write, reads zero, and produces a one-cycle `err` pulse on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_size | input | 2 | 0 byte, 1 half, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| err | output | 1 | Narrow-access pulse |
| evt_set | input | NCH*IW | Interrupt events from mover, IW bits per channel |
| halt_eol | input | NCH | Mover reached end of list |
| desc_eol | input | NCH | Current data descriptor carries end-of-list |
| reload_done | input | NCH | Reload finished |
| reload_eol | input | NCH | End-of-list mark of reloaded descriptor |
| irq | output | NCH | Interrupt per channel |
| load_data | output | NCH | Data-descriptor load pulse |
| load_ctx | output | NCH | Context-descriptor load pulse |
| start | output | NCH | Start pulse |
| reload_req | output | NCH | Continue reload pulse |
| advance | output | NCH | Step to next descriptor pulse |

## Verification
A corrupted state register shows up in the status word on the very next read, and a non-one-hot value is never legal. Wrong pending bits or a wrong mask show up on `irq` in the cycle after the offending write or event. A wrong gate on the continue path shows up as a `reload_req`, `advance` or `start` pulse one cycle after the triggering write or reply, or as a missing pulse. The status end-of-list bit then confirms the flag.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int NCH = 4,
  parameter int IW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [15:0]       bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              err,
  input  logic [NCH*IW-1:0] evt_set,
  input  logic [NCH-1:0]    halt_eol,
  input  logic [NCH-1:0]    desc_eol,
  input  logic [NCH-1:0]    reload_done,
  input  logic [NCH-1:0]    reload_eol,
  output logic [NCH-1:0]    irq,
  output logic [NCH-1:0]    load_data,
  output logic [NCH-1:0]    load_ctx,
  output logic [NCH-1:0]    start,
  output logic [NCH-1:0]    reload_req,
  output logic [NCH-1:0]    advance
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [5:0] A_DATA = 6'h00, A_SDATA = 6'h16, A_SBUF = 6'h17,
    A_GRP = 6'h18, A_GDN = 6'h1F, A_CMD = 6'h20, A_CFG = 6'h21, A_STAT = 6'h22,
    A_MASK = 6'h23, A_ACK = 6'h24, A_INTR = 6'h25, A_MINTR = 6'h26, A_SCMD = 6'h27;
  localparam logic [2:0] S_RST = 3'b001, S_STOP = 3'b010, S_RUN = 3'b100;

  logic [2:0]  chn;
  logic [5:0]  regi;
  logic        word, ch_ok, wr;
  logic [CW-1:0] chi;

  assign chn   = bus_addr[15:13];
  assign regi  = bus_addr[7:2];
  assign word  = bus_size == 2'd2;
  assign ch_ok = int'(chn) < NCH;
  assign chi   = chn[CW-1:0];
  assign wr    = bus_valid && bus_write && word && ch_ok;

  logic [NCH-1:0][31:0] data_q, sdata_q, sbuf_q, grp_q, gdn_q, cmd_q, cfg_q, mask_q;
  logic [NCH-1:0][9:0]  scmd_q;
  logic [NCH-1:0][IW-1:0] intr_q;
  logic [NCH-1:0][2:0]  state_q;
  logic [NCH-1:0]       eol_q, pend_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel, cfg_wr, go_stream, cont_ok, resume;
    logic [IW-1:0] ack;
    assign sel       = wr && chn == 3'(c);
    assign cfg_wr    = sel && regi == A_CFG;
    assign go_stream = sel && regi == A_SCMD && (|(bus_wdata[9:0] & 10'h140)) && bus_wdata[5];
    assign cont_ok   = sel && regi == A_CMD && cfg_q[c][0] && !cfg_q[c][1]
                       && state_q[c] == S_RUN && desc_eol[c];
    assign resume    = pend_q[c] && reload_done[c] && !reload_eol[c] && eol_q[c]
                       && cfg_q[c][0] && !cfg_q[c][1];
    assign ack       = (sel && regi == A_ACK) ? bus_wdata[IW-1:0] : '0;
    assign irq[c]    = |(intr_q[c] & mask_q[c][IW-1:0]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        data_q[c] <= '0; sdata_q[c] <= '0; sbuf_q[c] <= '0; grp_q[c] <= '0;
        gdn_q[c] <= '0; cmd_q[c] <= '0; cfg_q[c] <= '0; mask_q[c] <= '0;
        scmd_q[c] <= '0; intr_q[c] <= '0; state_q[c] <= S_RST;
        eol_q[c] <= 1'b0; pend_q[c] <= 1'b0;
        load_data[c] <= 1'b0; load_ctx[c] <= 1'b0; start[c] <= 1'b0;
        reload_req[c] <= 1'b0; advance[c] <= 1'b0;
      end else begin
        if (sel) begin
          case (regi)
            A_DATA:  data_q[c]  <= bus_wdata;
            A_SDATA: sdata_q[c] <= bus_wdata;
            A_SBUF:  sbuf_q[c]  <= bus_wdata;
            A_GRP:   grp_q[c]   <= bus_wdata;
            A_GDN:   gdn_q[c]   <= bus_wdata;
            A_CMD:   cmd_q[c]   <= bus_wdata;
            A_CFG:   cfg_q[c]   <= bus_wdata;
            A_MASK:  mask_q[c]  <= bus_wdata;
            A_SCMD:  scmd_q[c]  <= bus_wdata[9:0];
            default: ;
          endcase
        end
        intr_q[c] <= (intr_q[c] & ~ack) | evt_set[c*IW +: IW];
        if (cfg_wr) begin
          if (!bus_wdata[0])     state_q[c] <= S_RST;
          else if (bus_wdata[1]) state_q[c] <= S_STOP;
        end else if (go_stream || resume) begin
          state_q[c] <= S_RUN;
        end
        if (go_stream || resume) eol_q[c] <= 1'b0;
        else if (halt_eol[c])    eol_q[c] <= 1'b1;
        if (cont_ok)             pend_q[c] <= 1'b1;
        else if (reload_done[c]) pend_q[c] <= 1'b0;
        load_data[c]  <= sel && regi == A_SCMD && (|(bus_wdata[9:0] & 10'h140));
        load_ctx[c]   <= sel && regi == A_SCMD && bus_wdata[9];
        start[c]      <= go_stream || resume;
        reload_req[c] <= cont_ok;
        advance[c]    <= resume;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write && word && ch_ok) begin
      case (regi)
        A_DATA:  bus_rdata = data_q[chi];
        A_SDATA: bus_rdata = sdata_q[chi];
        A_SBUF:  bus_rdata = sbuf_q[chi];
        A_GRP:   bus_rdata = grp_q[chi];
        A_GDN:   bus_rdata = gdn_q[chi];
        A_CMD:   bus_rdata = cmd_q[chi];
        A_CFG:   bus_rdata = cfg_q[chi];
        A_STAT:  bus_rdata = {22'd0, 2'b01, 2'b00, eol_q[chi], 2'b00, state_q[chi]};
        A_MASK:  bus_rdata = mask_q[chi];
        A_INTR:  bus_rdata = 32'(intr_q[chi]);
        A_MINTR: bus_rdata = 32'(intr_q[chi] & mask_q[chi][IW-1:0]);
        A_SCMD:  bus_rdata = 32'(scmd_q[chi]);
        default: bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err <= 1'b0;
    else        err <= bus_valid && !word;
  end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int NCH = 4,
  parameter int IW  = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_valid,
  input logic                   bus_write,
  input logic [15:0]            bus_addr,
  input logic [1:0]             bus_size,
  input logic [31:0]            bus_wdata,
  input logic                   err,
  input logic [NCH*IW-1:0]      evt_set,
  input logic [NCH-1:0]         start,
  input logic [NCH-1:0]         reload_req,
  input logic [NCH-1:0]         advance,
  input logic [NCH-1:0][2:0]    state_q,
  input logic [NCH-1:0][IW-1:0] intr_q,
  input logic [NCH-1:0]         eol_q
);
  logic narrow;
  assign narrow = bus_valid && bus_size != 2'd2;

  assert_narrow_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    narrow |=> err);
  assert_err_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(narrow));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic ack_hit;
    assign ack_hit = bus_valid && bus_write && bus_size == 2'd2 &&
                     bus_addr[15:13] == 3'(c) && bus_addr[7:2] == 6'h24;
    assert_state_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(state_q[c]) == 1);
    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ack_hit |=> ((intr_q[c] & $past(bus_wdata[IW-1:0]) & ~$past(evt_set[c*IW +: IW])) == '0));
    assert_start_runs_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start[c] |-> (state_q[c] == 3'b100 && !eol_q[c]));
    assert_reload_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      reload_req[c] |-> $past(state_q[c] == 3'b100));
    assert_advance_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      advance[c] |-> start[c]);
  end
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NCH(NCH), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata), .err(err),
  .evt_set(evt_set), .start(start), .reload_req(reload_req), .advance(advance),
  .state_q(state_q), .intr_q(intr_q), .eol_q(eol_q)
);

// File: tb/test_dma_chan_regs.sv
module test_dma_chan_regs;
  localparam int NCH = 4, IW = 4;
  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [15:0] bus_addr = '0;
  logic [1:0] bus_size = 2'd2;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic err;
  logic [NCH*IW-1:0] evt_set = '0;
  logic [NCH-1:0] halt_eol = '0, desc_eol = '0, reload_done = '0, reload_eol = '0;
  logic [NCH-1:0] irq, load_data, load_ctx, start, reload_req, advance;
  int checks = 0, errors = 0;
  bit done = 0;

  dma_chan_regs #(.NCH(NCH), .IW(IW)) i_dma_chan_regs (.*);

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input logic [7:0] off, input logic [31:0] v, input logic [1:0] sz = 2);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = {3'(ch), 5'd0, off}; bus_wdata = v; bus_size = sz;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; bus_size = 2;
  endtask

  task automatic rd(input int ch, input logic [7:0] off, output logic [31:0] v, input logic [1:0] sz = 2);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = {3'(ch), 5'd0, off}; bus_size = sz;
    #1 v = bus_rdata;
    bus_valid = 0; bus_size = 2;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(0, 8'h88, v); chk("R2 status", v, 32'h101);
    rd(0, 8'h84, v); chk("R2 cfg", v, 0);
    chk("R2 irq", 32'(irq), 0);
  endtask

  task automatic t_decode;
    logic [31:0] v;
    wr(1, 8'h7C, 32'hCAFE0001);
    rd(1, 8'h7C, v); chk("R1 group down", v, 32'hCAFE0001);
    rd(2, 8'h7C, v); chk("R1 other channel", v, 0);
    wr(3, 8'h5C, 32'h1234);
    rd(3, 8'h5C, v); chk("R1 saved buf", v, 32'h1234);
    wr(7, 8'h00, 32'hFFFF);
    rd(7, 8'h00, v); chk("R1 channel out of range", v, 0);
    rd(1, 8'hA0, v); chk("R1 unused offset", v, 0);
  endtask

  task automatic t_cfg;
    logic [31:0] v;
    wr(2, 8'h84, 32'h1);
    rd(2, 8'h88, v); chk("R3 enable keeps RST", v, 32'h101);
    wr(2, 8'h84, 32'h3);
    rd(2, 8'h88, v); chk("R3 stop", v, 32'h102);
    wr(2, 8'h84, 32'h2);
    rd(2, 8'h88, v); chk("R3 bit0 clear wins", v, 32'h101);
  endtask

  task automatic t_stream;
    logic [31:0] v;
    wr(1, 8'h9C, 32'h160);
    chk("R7 load_data", 32'(load_data), 32'h2);
    chk("R7 start", 32'(start), 32'h2);
    rd(1, 8'h88, v); chk("R8 running", v, 32'h104);
    wr(1, 8'h9C, 32'h140);
    chk("R7 load only", 32'(load_data), 32'h2);
    chk("R7 no start", 32'(start), 0);
    wr(1, 8'h9C, 32'h200);
    chk("R7 ctx", 32'(load_ctx), 32'h2);
    chk("R7 ctx no data", 32'(load_data), 0);
    wr(1, 8'h9C, 32'h420);
    chk("R7 high bits dropped", 32'({load_data, load_ctx, start}), 0);
    rd(1, 8'h9C, v); chk("R7 low ten bits", v, 32'h020);
  endtask

  task automatic t_intr;
    logic [31:0] v;
    @(negedge clk); evt_set = 16'h0040; // channel 1 bit 2
    @(negedge clk); evt_set = '0;
    rd(1, 8'h94, v); chk("R5 pending", v, 32'h4);
    rd(1, 8'h98, v); chk("R6 masked zero", v, 0);
    chk("R6 irq off", 32'(irq), 0);
    wr(1, 8'h8C, 32'hC);
    chk("R6 irq on", 32'(irq), 32'h2);
    rd(1, 8'h98, v); chk("R6 masked", v, 32'h4);
    wr(1, 8'h90, 32'h4);
    rd(1, 8'h94, v); chk("R5 ack cleared", v, 0);
    chk("R6 irq cleared", 32'(irq), 0);
    rd(1, 8'h90, v); chk("R5 ack reads zero", v, 0);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = {3'd1, 5'd0, 8'h90}; bus_wdata = 32'h8;
    evt_set = 16'h0080;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; evt_set = '0;
    rd(1, 8'h94, v); chk("R5 event beats ack", v, 32'h8);
  endtask

  task automatic t_continue;
    logic [31:0] v;
    wr(0, 8'h84, 32'h1);
    wr(0, 8'h9C, 32'h160);
    @(negedge clk); halt_eol = 4'h1;
    @(negedge clk); halt_eol = 0;
    rd(0, 8'h88, v); chk("R4 eol bit", v, 32'h124);
    desc_eol = 0;
    wr(0, 8'h80, 32'h1);
    chk("R9 no reload without eol", 32'(reload_req), 0);
    desc_eol = 4'h1;
    wr(0, 8'h80, 32'h1);
    chk("R9 reload", 32'(reload_req), 32'h1);
    reload_done = 4'h1; reload_eol = 4'h1;
    @(negedge clk); reload_done = 0; reload_eol = 0;
    chk("R10 still at end", 32'({advance, start}), 0);
    rd(0, 8'h88, v); chk("R10 eol kept", v, 32'h124);
    wr(0, 8'h80, 32'h1);
    reload_done = 4'h1;
    @(negedge clk); reload_done = 0;
    chk("R10 advance", 32'(advance), 32'h1);
    chk("R10 restart", 32'(start), 32'h1);
    rd(0, 8'h88, v); chk("R10 eol cleared", v, 32'h104);
    wr(0, 8'h84, 32'h3);
    wr(0, 8'h80, 32'h1);
    chk("R9 stopped no reload", 32'(reload_req), 0);
    desc_eol = 0;
  endtask

  task automatic t_narrow;
    logic [31:0] v;
    wr(3, 8'h84, 32'h3, 2'd0);
    chk("R11 err pulse", 32'(err), 1);
    rd(3, 8'h84, v); chk("R11 write ignored", v, 0);
    rd(3, 8'h5C, v, 2'd1); chk("R11 narrow read zero", v, 0);
    @(negedge clk); chk("R11 err single", 32'(err), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_decode; t_cfg; t_stream; t_intr; t_continue; t_narrow;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); errors++; $display("FAIL watchdog expired"); end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule